// File: doc/BRIEF.md
# Power management event register block

This block holds the byte-wide registers through which firmware and an operating system handle power management events. A primary window of sixteen bytes carries the event status, event enable and event control words. A secondary window of eight bytes carries an auxiliary status and enable pair and a small firmware register set: firmware status, firmware enable and firmware control. Hardware event sources set status bits through set vectors. Software clears them by writing ones. Enabled status is combined into a level-sensitive system control interrupt (SCI). A firmware interrupt request (SMI) is raised as a single-cycle pulse.

Two handshakes link the windows. In the first, firmware writes its control register to hand work to the operating system, and that write sets bits in the event status word. In the second, the operating system writes a release bit in the event control word, which sets a firmware status bit and can request an SMI. Clearing the global event status bit also withdraws the firmware release. Each access is one byte per cycle. Reads are combinational from the addressed register.

Top module: `pmev_regs`

## Requirements
- R1: After reset every register reads 0x00, sci_o is low and smi_o is low.
- R2: Primary window (acc_aux=0), byte offsets: 0/1 event status, 2/3 event enable, 4/5 event control. The low byte is at the even offset. Event enable and event control take the written byte as is. Offsets 6 to 15 read 0x00 and ignore writes.
- R3: Secondary window (acc_aux=1) decodes only acc_addr[2:0], so acc_addr[3] is ignored. Offsets: 0/1 auxiliary status, 2/3 auxiliary enable, 4/5 firmware status, 6 firmware enable, 7 firmware control.
- R4: Writing a 1 to an event status bit clears that bit. A 1 on evt_set sets the bit, and a set wins over a clear in the same cycle.
- R5: Auxiliary status bits are set by aux_set. Writing ones clears only bits 2 and 3. Auxiliary enable keeps bits 13:0 and reads zero above them.
- R6: Firmware status is 5 bits wide. fw_set sets its bits and writing ones clears them. Firmware enable and firmware control keep bits 1:0 only.
- R7: A write to firmware control with data bit 0 set sets event status bit 5. A write with data bit 1 set sets event status bit 4.
- R8: sci_o is registered. It goes high one cycle after event status and event enable share a set bit among bits 10, 8, 5 and 0, or after event status bit 4 is set on its own.
- R9: A write to primary offset 4 with data bit 2 set sets firmware status bit 0. If firmware enable bit 0 and firmware control bit 0 were both set before that write, smi_o is high for exactly the next cycle.
- R10: A write to primary offset 0 that leaves event status bit 5 clear also clears firmware control bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| acc_wr | input | 1 | Byte write strobe |
| acc_aux | input | 1 | Window select: 0 primary, 1 secondary |
| acc_addr | input | 4 | Byte offset within the selected window |
| acc_wdata | input | 8 | Write data |
| acc_rdata | output | 8 | Read data of the addressed byte |
| evt_set | input | 16 | Hardware set pulses for event status |
| aux_set | input | 16 | Hardware set pulses for auxiliary status |
| fw_set | input | 5 | Hardware set pulses for firmware status |
| sci_o | output | 1 | SCI level |
| smi_o | output | 1 | SMI request pulse |

## Verification
Directed sequences come first. Each tests one path in isolation: an enabled source against a disabled one for SCI, bit 4 raising SCI with no enable set, a set and a clear landing on the same word, writes to bits that cannot be cleared, and each direction of the release handshake with its gate bits both set and clear. These tell a wrong mask or a wrong cross-post apart from a wrong byte lane. A long random phase then mixes writes, reads, window aliasing and sparse hardware sets. A reference model is compared against the design on every cycle. This exposes errors in ordering, such as a clear that should see a same-cycle set, or an SMI gate that must use the state from before the write.

// File: rtl/pmev_pkg.sv
package pmev_pkg;
   localparam int unsigned REG_W = 16;
   typedef logic [REG_W-1:0] word_t;

   typedef enum logic {REG_RW, REG_W1C} reg_kind_e;

   // Word indices (byte offset >> 1) in the primary window
   localparam int unsigned P_EVT_STS = 0;
   localparam int unsigned P_EVT_EN  = 1;
   localparam int unsigned P_EVT_CTL = 2;
   // Word indices in the secondary window
   localparam int unsigned A_AUX_STS = 0;
   localparam int unsigned A_AUX_EN  = 1;
   localparam int unsigned A_FW_STS  = 2;
   localparam int unsigned A_FW_PAIR = 3;

   // Bit positions the handshakes depend on
   localparam int unsigned B_GBL  = 5;
   localparam int unsigned B_BM   = 4;
   localparam int unsigned B_GRLS = 2;
endpackage

// File: rtl/pmev_field.sv
module pmev_field
   import pmev_pkg::*;
#(
   parameter int unsigned W        = 16,
   parameter reg_kind_e   KIND     = REG_RW,
   parameter word_t       CLR_MASK = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_lo,
   input  logic         wr_hi,
   input  logic [7:0]   wdata,
   input  logic [W-1:0] set,
   input  logic [W-1:0] clr,
   output logic [W-1:0] q
);
   if (W < 1 || W > REG_W) begin : g_bad_w
      $error("pmev_field: W out of range");
   end

   logic [W-1:0] lane, wv, nxt;
   logic         unused_ok;

   for (genvar i = 0; i < W; i++) begin : g_bit
      if (i < 8) begin : g_lo
         assign lane[i] = wr_lo;
      end else begin : g_hi
         assign lane[i] = wr_hi;
      end
      assign wv[i] = wdata[i % 8];
   end

   assign unused_ok = &{1'b0, wr_hi, wdata};

   if (KIND == REG_W1C) begin : g_w1c
      assign nxt = ((q & ~(wv & lane & CLR_MASK[W-1:0])) & ~clr) | set;
   end else begin : g_rw
      assign nxt = (((q & ~lane) | (wv & lane)) & ~clr) | set;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= nxt;
   end
endmodule

// File: rtl/pmev_sci_gen.sv
module pmev_sci_gen
   import pmev_pkg::*;
#(
   parameter bit    REGISTERED = 1'b1,
   parameter word_t SRC_MASK   = 16'h0521,
   parameter int unsigned BM_BIT = B_BM
) (
   input  logic  clk,
   input  logic  rst_n,
   input  word_t sts,
   input  word_t en,
   output logic  sci
);
   logic level;
   assign level = (|(sts & en & SRC_MASK)) | sts[BM_BIT];

   if (REGISTERED) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sci <= 1'b0;
         else        sci <= level;
      end
   end else begin : g_comb
      logic unused_clk;
      assign unused_clk = clk ^ rst_n;
      assign sci = level;
   end
endmodule

// File: rtl/pmev_regs.sv
module pmev_regs
   import pmev_pkg::*;
#(
   parameter int unsigned PRIM_BYTES     = 16,
   parameter int unsigned AUX_BYTES      = 8,
   parameter int unsigned AUX_EN_BITS    = 14,
   parameter int unsigned FW_STS_BITS    = 5,
   parameter int unsigned FW_BITS        = 2,
   parameter word_t       AUX_CLR_MASK   = 16'h000C,
   parameter word_t       SCI_SRC_MASK   = 16'h0521,
   parameter bit          SCI_REGISTERED = 1'b1,
   localparam int unsigned ADDR_W        = $clog2(PRIM_BYTES),
   localparam int unsigned AUX_AW        = $clog2(AUX_BYTES)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   acc_wr,
   input  logic                   acc_aux,
   input  logic [ADDR_W-1:0]      acc_addr,
   input  logic [7:0]             acc_wdata,
   output logic [7:0]             acc_rdata,
   input  logic [REG_W-1:0]       evt_set,
   input  logic [REG_W-1:0]       aux_set,
   input  logic [FW_STS_BITS-1:0] fw_set,
   output logic                   sci_o,
   output logic                   smi_o
);
   if (AUX_BYTES != 8 || PRIM_BYTES < 8 || (1 << ADDR_W) != PRIM_BYTES) begin : g_bad_map
      $error("pmev_regs: unsupported window sizes");
   end
   if (AUX_EN_BITS > REG_W || FW_STS_BITS > 8 || FW_BITS > 8 || FW_BITS < 2) begin : g_bad_width
      $error("pmev_regs: field width out of range");
   end

   // Decode
   logic                wr_p, wr_a;
   logic [ADDR_W-2:0]   p_word;
   logic [AUX_AW-2:0]   a_word;
   logic                byte_hi;

   assign wr_p    = acc_wr & ~acc_aux;
   assign wr_a    = acc_wr &  acc_aux;
   assign p_word  = acc_addr[ADDR_W-1:1];
   assign a_word  = acc_addr[AUX_AW-1:1];
   assign byte_hi = acc_addr[0];

   function automatic logic hit_p(input logic [ADDR_W-2:0] w, input int unsigned k);
      return w == (ADDR_W-1)'(k);
   endfunction
   function automatic logic hit_a(input logic [AUX_AW-2:0] w, input int unsigned k);
      return w == (AUX_AW-1)'(k);
   endfunction

   logic wp_sts, wp_en, wp_ctl, wa_sts, wa_en, wa_fw, wa_fwen, wa_fwctl;
   assign wp_sts   = wr_p & hit_p(p_word, P_EVT_STS);
   assign wp_en    = wr_p & hit_p(p_word, P_EVT_EN);
   assign wp_ctl   = wr_p & hit_p(p_word, P_EVT_CTL);
   assign wa_sts   = wr_a & hit_a(a_word, A_AUX_STS);
   assign wa_en    = wr_a & hit_a(a_word, A_AUX_EN);
   assign wa_fw    = wr_a & hit_a(a_word, A_FW_STS);
   assign wa_fwen  = wr_a & hit_a(a_word, A_FW_PAIR) & ~byte_hi;
   assign wa_fwctl = wr_a & hit_a(a_word, A_FW_PAIR) &  byte_hi;

   // Handshake strobes
   logic grls_wr, gbl_after, gbl_drop;
   word_t evt_sts_set;
   logic [FW_STS_BITS-1:0] fw_sts_set;
   logic [FW_BITS-1:0]     fw_ctl_clr;

   assign grls_wr = wp_ctl & ~byte_hi & acc_wdata[B_GRLS];

   always_comb begin
      evt_sts_set        = evt_set;
      evt_sts_set[B_GBL] = evt_set[B_GBL] | (wa_fwctl & acc_wdata[0]);
      evt_sts_set[B_BM]  = evt_set[B_BM]  | (wa_fwctl & acc_wdata[1]);
      fw_sts_set         = fw_set;
      fw_sts_set[0]      = fw_set[0] | grls_wr;
   end

   // Register state
   word_t                  evt_sts_q, evt_en_q, evt_ctl_q, aux_sts_q;
   logic [AUX_EN_BITS-1:0] aux_en_q;
   logic [FW_STS_BITS-1:0] fw_sts_q;
   logic [FW_BITS-1:0]     fw_en_q, fw_ctl_q;

   assign gbl_after = (evt_sts_q[B_GBL] & ~(wp_sts & ~byte_hi & acc_wdata[B_GBL]))
                    | evt_sts_set[B_GBL];
   assign gbl_drop  = wp_sts & ~byte_hi & ~gbl_after;
   always_comb begin
      fw_ctl_clr    = '0;
      fw_ctl_clr[0] = gbl_drop;
   end

   pmev_field #(.W(REG_W), .KIND(REG_W1C), .CLR_MASK('1)) u_evt_sts (
      .clk, .rst_n, .wr_lo(wp_sts & ~byte_hi), .wr_hi(wp_sts & byte_hi),
      .wdata(acc_wdata), .set(evt_sts_set), .clr('0), .q(evt_sts_q));

   pmev_field #(.W(REG_W), .KIND(REG_RW)) u_evt_en (
      .clk, .rst_n, .wr_lo(wp_en & ~byte_hi), .wr_hi(wp_en & byte_hi),
      .wdata(acc_wdata), .set('0), .clr('0), .q(evt_en_q));

   pmev_field #(.W(REG_W), .KIND(REG_RW)) u_evt_ctl (
      .clk, .rst_n, .wr_lo(wp_ctl & ~byte_hi), .wr_hi(wp_ctl & byte_hi),
      .wdata(acc_wdata), .set('0), .clr('0), .q(evt_ctl_q));

   pmev_field #(.W(REG_W), .KIND(REG_W1C), .CLR_MASK(AUX_CLR_MASK)) u_aux_sts (
      .clk, .rst_n, .wr_lo(wa_sts & ~byte_hi), .wr_hi(wa_sts & byte_hi),
      .wdata(acc_wdata), .set(aux_set), .clr('0), .q(aux_sts_q));

   pmev_field #(.W(AUX_EN_BITS), .KIND(REG_RW)) u_aux_en (
      .clk, .rst_n, .wr_lo(wa_en & ~byte_hi), .wr_hi(wa_en & byte_hi),
      .wdata(acc_wdata), .set('0), .clr('0), .q(aux_en_q));

   pmev_field #(.W(FW_STS_BITS), .KIND(REG_W1C), .CLR_MASK('1)) u_fw_sts (
      .clk, .rst_n, .wr_lo(wa_fw & ~byte_hi), .wr_hi(1'b0),
      .wdata(acc_wdata), .set(fw_sts_set), .clr('0), .q(fw_sts_q));

   pmev_field #(.W(FW_BITS), .KIND(REG_RW)) u_fw_en (
      .clk, .rst_n, .wr_lo(wa_fwen), .wr_hi(1'b0),
      .wdata(acc_wdata), .set('0), .clr('0), .q(fw_en_q));

   pmev_field #(.W(FW_BITS), .KIND(REG_RW)) u_fw_ctl (
      .clk, .rst_n, .wr_lo(wa_fwctl), .wr_hi(1'b0),
      .wdata(acc_wdata), .set('0), .clr(fw_ctl_clr), .q(fw_ctl_q));

   // SCI and SMI
   pmev_sci_gen #(.REGISTERED(SCI_REGISTERED), .SRC_MASK(SCI_SRC_MASK), .BM_BIT(B_BM)) u_sci (
      .clk, .rst_n, .sts(evt_sts_q), .en(evt_en_q), .sci(sci_o));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) smi_o <= 1'b0;
      else        smi_o <= grls_wr & fw_en_q[0] & fw_ctl_q[0];
   end

   // Read path
   function automatic logic [7:0] pick(input word_t w, input logic hi);
      return hi ? w[15:8] : w[7:0];
   endfunction

   always_comb begin
      acc_rdata = 8'h00;
      if (!acc_aux) begin
         if (hit_p(p_word, P_EVT_STS))      acc_rdata = pick(evt_sts_q, byte_hi);
         else if (hit_p(p_word, P_EVT_EN))  acc_rdata = pick(evt_en_q, byte_hi);
         else if (hit_p(p_word, P_EVT_CTL)) acc_rdata = pick(evt_ctl_q, byte_hi);
      end else begin
         if (hit_a(a_word, A_AUX_STS))      acc_rdata = pick(aux_sts_q, byte_hi);
         else if (hit_a(a_word, A_AUX_EN))  acc_rdata = pick(REG_W'(aux_en_q), byte_hi);
         else if (hit_a(a_word, A_FW_STS))  acc_rdata = pick(REG_W'(fw_sts_q), byte_hi);
         else if (byte_hi)                  acc_rdata = 8'(fw_ctl_q);
         else                               acc_rdata = 8'(fw_en_q);
      end
   end
endmodule

// File: rtl/pmev_chk.sv
module pmev_chk #(
   parameter int unsigned ADDR_W         = 4,
   parameter bit          SCI_REGISTERED = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              acc_wr,
   input logic              acc_aux,
   input logic [ADDR_W-1:0] acc_addr,
   input logic [7:0]        acc_wdata,
   input logic [15:0]       evt_set,
   input logic [15:0]       evt_sts,
   input logic              fw_ctl0,
   input logic              aux_sts0,
   input logic              sci_o,
   input logic              smi_o
);
   logic fwctl_wr, gbl_wr_lo;
   assign fwctl_wr  = acc_wr && acc_aux && (acc_addr[2:0] == 3'd7);
   assign gbl_wr_lo = acc_wr && !acc_aux && (acc_addr == ADDR_W'(0));

   p_smi_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
      smi_o |-> $past(acc_wr && !acc_aux && (acc_addr == ADDR_W'(4)) && acc_wdata[2]));

   p_bios_rls_gbl_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (fwctl_wr && acc_wdata[0]) |=> evt_sts[5]);

   p_bm_rls_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (fwctl_wr && acc_wdata[1]) |=> evt_sts[4]);

   p_gbl_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (gbl_wr_lo && !evt_set[5] && (acc_wdata[5] || !evt_sts[5])) |=> !fw_ctl0);

   p_aux_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_wr && acc_aux && (acc_addr[2:0] == 3'd0) && aux_sts0) |=> aux_sts0);

   if (SCI_REGISTERED) begin : g_sci_reg
      p_bm_sci_r8: assert property (@(posedge clk) disable iff (!rst_n)
         evt_sts[4] |=> sci_o);
   end else begin : g_sci_comb
      p_bm_sci_r8: assert property (@(posedge clk) disable iff (!rst_n)
         evt_sts[4] |-> sci_o);
   end
endmodule

bind pmev_regs pmev_chk #(.ADDR_W(ADDR_W), .SCI_REGISTERED(SCI_REGISTERED)) u_chk (
   .clk(clk), .rst_n(rst_n), .acc_wr(acc_wr), .acc_aux(acc_aux), .acc_addr(acc_addr),
   .acc_wdata(acc_wdata), .evt_set(evt_set), .evt_sts(evt_sts_q), .fw_ctl0(fw_ctl_q[0]),
   .aux_sts0(aux_sts_q[0]), .sci_o(sci_o), .smi_o(smi_o));

// File: tb/tb_pmev_regs.sv
`timescale 1ns/100ps
module tb_pmev_regs;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        acc_wr = 1'b0, acc_aux = 1'b0;
   logic [3:0]  acc_addr = '0;
   logic [7:0]  acc_wdata = '0;
   logic [7:0]  acc_rdata;
   logic [15:0] evt_set = '0, aux_set = '0;
   logic [4:0]  fw_set = '0;
   logic        sci_o, smi_o;

   int vectors = 0, miscompares = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   pmev_regs dut (
      .clk, .rst_n, .acc_wr, .acc_aux, .acc_addr, .acc_wdata, .acc_rdata,
      .evt_set, .aux_set, .fw_set, .sci_o, .smi_o);

   // Reference model state
   logic [15:0] m_evt_sts = '0, m_evt_en = '0, m_evt_ctl = '0, m_aux_sts = '0, m_aux_en = '0;
   logic [15:0] m_fw_sts = '0, m_fw_en = '0, m_fw_ctl = '0;
   logic        m_sci = 1'b0, m_smi = 1'b0;

   task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic logic [7:0] lane(input logic [15:0] w, input logic hi);
      return hi ? w[15:8] : w[7:0];
   endfunction

   function automatic logic [7:0] m_read(input logic aux, input logic [3:0] a);
      if (!aux) begin
         case (a)
            4'd0, 4'd1: return lane(m_evt_sts, a[0]);
            4'd2, 4'd3: return lane(m_evt_en, a[0]);
            4'd4, 4'd5: return lane(m_evt_ctl, a[0]);
            default:    return 8'h00;
         endcase
      end
      case (a[2:0])
         3'd0, 3'd1: return lane(m_aux_sts, a[0]);
         3'd2, 3'd3: return lane(m_aux_en, a[0]);
         3'd4, 3'd5: return lane(m_fw_sts, a[0]);
         3'd6:       return m_fw_en[7:0];
         default:    return m_fw_ctl[7:0];
      endcase
   endfunction

   function automatic string rd_tag(input logic aux, input logic [3:0] a);
      if (aux && a[3]) return "R3";
      if (!aux) return (a < 4'd2) ? "R4" : "R2";
      if (a[2:0] < 3'd4) return "R5";
      return "R6";
   endfunction

   task automatic model_update(input logic wr, input logic aux, input logic [3:0] a,
                               input logic [7:0] wd, input logic [15:0] es,
                               input logic [15:0] as, input logic [4:0] fs);
      int sh = a[0] ? 8 : 0;
      logic [15:0] wv = 16'(wd) << sh;
      logic [15:0] bm = 16'hFF << sh;
      m_sci = (|(m_evt_sts & m_evt_en & 16'h0521)) | m_evt_sts[4];
      m_smi = 1'b0;
      if (wr && !aux) begin
         case (a)
            4'd0, 4'd1: m_evt_sts = m_evt_sts & ~wv;
            4'd2, 4'd3: m_evt_en  = (m_evt_en & ~bm) | wv;
            4'd4, 4'd5: begin
               m_evt_ctl = (m_evt_ctl & ~bm) | wv;
               if (a == 4'd4 && wd[2]) begin
                  if (m_fw_en[0] && m_fw_ctl[0]) m_smi = 1'b1;
                  m_fw_sts[0] = 1'b1;
               end
            end
            default: ;
         endcase
      end else if (wr && aux) begin
         case (a[2:0])
            3'd0, 3'd1: m_aux_sts = m_aux_sts & ~(wv & 16'h000C);
            3'd2, 3'd3: m_aux_en  = ((m_aux_en & ~bm) | wv) & 16'h3FFF;
            3'd4, 3'd5: m_fw_sts  = m_fw_sts & ~(wv & 16'h001F);
            3'd6:       m_fw_en   = 16'(wd) & 16'h3;
            default: begin
               m_fw_ctl = 16'(wd) & 16'h3;
               if (wd[0]) m_evt_sts[5] = 1'b1;
               if (wd[1]) m_evt_sts[4] = 1'b1;
            end
         endcase
      end
      m_evt_sts = m_evt_sts | es;
      m_aux_sts = m_aux_sts | as;
      m_fw_sts  = m_fw_sts | 16'(fs);
      if (wr && !aux && a == 4'd0 && !m_evt_sts[5]) m_fw_ctl[0] = 1'b0;
   endtask

   task automatic step(input logic wr, input logic aux, input logic [3:0] a,
                       input logic [7:0] wd, input logic [15:0] es = '0,
                       input logic [15:0] as = '0, input logic [4:0] fs = '0);
      acc_wr = wr; acc_aux = aux; acc_addr = a; acc_wdata = wd;
      evt_set = es; aux_set = as; fw_set = fs;
      @(posedge clk);
      model_update(wr, aux, a, wd, es, as, fs);
      @(negedge clk);
      check(rd_tag(aux, a), 16'(acc_rdata), 16'(m_read(aux, a)));
      check("R8", 16'(sci_o), 16'(m_sci));
      check("R9", 16'(smi_o), 16'(m_smi));
   endtask

   task automatic rd(input logic aux, input logic [3:0] a);
      step(1'b0, aux, a, 8'h00);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   endtask

   initial begin
      #500000;
      vectors++;
      miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (4) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state on every byte of both windows
      check("R1", 16'(sci_o), 16'h0);
      check("R1", 16'(smi_o), 16'h0);
      for (int i = 0; i < 16; i++) begin
         rd(1'b0, 4'(i));
         check("R1", 16'(acc_rdata), 16'h0);
      end
      for (int i = 0; i < 8; i++) begin
         rd(1'b1, 4'(i));
         check("R1", 16'(acc_rdata), 16'h0);
      end

      // R2: enable lanes
      step(1'b1, 1'b0, 4'd2, 8'h20);
      step(1'b1, 1'b0, 4'd3, 8'h05);
      rd(1'b0, 4'd2); check("R2", 16'(acc_rdata), 16'h20);
      rd(1'b0, 4'd3); check("R2", 16'(acc_rdata), 16'h05);
      step(1'b1, 1'b0, 4'd9, 8'hAA);
      rd(1'b0, 4'd9); check("R2", 16'(acc_rdata), 16'h00);

      // R8: enabled global bit, then bit 4 without enable
      step(1'b0, 1'b0, 4'd0, 8'h00, 16'h0020);
      rd(1'b0, 4'd0); check("R8", 16'(sci_o), 16'h1);
      step(1'b1, 1'b0, 4'd0, 8'h20);
      rd(1'b0, 4'd0); check("R8", 16'(sci_o), 16'h0);
      step(1'b0, 1'b0, 4'd0, 8'h00, 16'h0010);
      rd(1'b0, 4'd0); check("R8", 16'(sci_o), 16'h1);
      step(1'b1, 1'b0, 4'd0, 8'h10);
      rd(1'b0, 4'd0);

      // R4: clear on high lane, set beats clear in the same cycle
      step(1'b0, 1'b0, 4'd0, 8'h00, 16'h0300);
      step(1'b1, 1'b0, 4'd1, 8'h01);
      rd(1'b0, 4'd1); check("R4", 16'(acc_rdata), 16'h02);
      step(1'b1, 1'b0, 4'd1, 8'h02, 16'h0200);
      rd(1'b0, 4'd1); check("R4", 16'(acc_rdata), 16'h02);

      // R7: firmware release cross-posts into event status
      step(1'b1, 1'b1, 4'd7, 8'h03);
      rd(1'b0, 4'd0); check("R7", 16'(acc_rdata & 8'h30), 16'h30);

      // R9: global release with both gate bits set
      step(1'b1, 1'b1, 4'd6, 8'h01);
      step(1'b1, 1'b0, 4'd4, 8'h04);
      check("R9", 16'(smi_o), 16'h1);
      rd(1'b1, 4'd4);
      check("R9", 16'(smi_o), 16'h0);
      check("R9", 16'(acc_rdata[0]), 16'h1);
      step(1'b1, 1'b1, 4'd6, 8'h00);
      step(1'b1, 1'b0, 4'd4, 8'h04);
      check("R9", 16'(smi_o), 16'h0);

      // R10: dropping the global status withdraws firmware release
      step(1'b1, 1'b0, 4'd0, 8'h20);
      rd(1'b1, 4'd7); check("R10", 16'(acc_rdata), 16'h02);

      // R5: only bits 2 and 3 clear, enable keeps 14 bits
      step(1'b0, 1'b1, 4'd0, 8'h00, 16'h0, 16'hFFFF);
      step(1'b1, 1'b1, 4'd0, 8'hFF);
      step(1'b1, 1'b1, 4'd1, 8'hFF);
      rd(1'b1, 4'd0); check("R5", 16'(acc_rdata), 16'hF3);
      rd(1'b1, 4'd1); check("R5", 16'(acc_rdata), 16'hFF);
      step(1'b1, 1'b1, 4'd3, 8'hFF);
      rd(1'b1, 4'd3); check("R5", 16'(acc_rdata), 16'h3F);

      // R6: firmware widths and clear
      step(1'b1, 1'b1, 4'd6, 8'hFF);
      rd(1'b1, 4'd6); check("R6", 16'(acc_rdata), 16'h03);
      step(1'b0, 1'b1, 4'd4, 8'h00, 16'h0, 16'h0, 5'h1F);
      rd(1'b1, 4'd4); check("R6", 16'(acc_rdata), 16'h1F);
      step(1'b1, 1'b1, 4'd4, 8'hFF);
      rd(1'b1, 4'd4); check("R6", 16'(acc_rdata), 16'h00);

      // R3: upper address bit ignored in the secondary window
      rd(1'b1, 4'd14); check("R3", 16'(acc_rdata), 16'h03);

      // Mixed random traffic against the reference model
      for (int n = 0; n < 4000; n++) begin
         step(1'($urandom), 1'($urandom), 4'($urandom), 8'($urandom),
              16'($urandom & $urandom & $urandom & $urandom),
              16'($urandom & $urandom & $urandom),
              5'($urandom & $urandom & $urandom));
      end
      finish_run();
   end
endmodule